// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block sits in an OFDM transmit chain, downstream of the scrambler and upstream of the interleaver. It accepts one scrambled bit at a time through a valid/ready handshake. It runs each bit through a rate-1/2, constraint-length-7 convolutional code. It then removes selected coded bits, so the stream that leaves the block is coded at rate 1/2, 2/3 or 3/4. Coded bits leave serially, one per cycle, marked by an output valid.

The stream is opened by a start pulse. The start pulse clears the encoder history and the puncturing position, and it drops any coded bits still waiting to leave. The puncturing stage has its own enable. When that enable is low, every coded bit is kept whatever rate is selected. The input ready signal is held low while coded bits are still pending, so an upstream source never loses a bit during a two-bit output burst.

The controller has four states:
- ST_IDLE is the state after reset. It leaves only on start.
- ST_READY accepts input.
- ST_SEND_A drives the first-kept output bit.
- ST_SEND_B drives the second output bit.

Its transitions are:
- Start moves any state to ST_READY.
- An accepted bit moves ST_READY to ST_SEND_A when output A is kept. It moves to ST_SEND_B when only output B is kept.
- ST_SEND_A moves to ST_SEND_B when B is also kept, and otherwise back to ST_READY.
- ST_SEND_B always returns to ST_READY.

Top module: `conv_punct_enc`

## Requirements
- R1: After reset, and until the first start pulse, din_ready and dout_valid stay low and din_valid has no effect.
- R2: Each accepted bit d yields two coded bits. A is d xor the inputs 2, 3, 5 and 6 bits back (generator 133 octal). B is d xor the inputs 1, 2, 3 and 6 bits back (generator 171 octal). A is sent before B.
- R3: rate_sel encodes the rate: 2'b00 selects rate 1/2, 2'b01 rate 2/3, 2'b10 rate 3/4, and 2'b11 behaves as rate 1/2.
- R4: At rate 2/3 with punc_en high, input bits are numbered from 0 after start. An even-numbered bit sends A then B; an odd-numbered bit sends only A.
- R5: At rate 3/4 with punc_en high, the input bit number modulo 3 selects the output. Position 0 sends A then B, position 1 sends only A, and position 2 sends only B.
- R6: With punc_en low, every accepted bit sends both A and B at any rate_sel value.
- R7: A start pulse clears the encoder history and the puncturing position to zero and drops pending output bits. In the next cycle dout_valid is low and din_ready is high. A din_valid in the same cycle as start is not accepted.
- R8: din_ready is high only when no coded bit is pending, and it is never high in a cycle where dout_valid is high. A bit is accepted exactly when din_valid and din_ready are both high and start is low.
- R9: The first kept bit appears on dout, with dout_valid high, in the cycle after acceptance. A second kept bit follows in the next cycle. dout_valid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that opens a new coded stream |
| din | input | 1 | Scrambled input bit |
| din_valid | input | 1 | din carries a bit |
| din_ready | output | 1 | Block can take an input bit this cycle |
| rate_sel | input | 2 | Code rate select (see R3) |
| punc_en | input | 1 | Enables removal of coded bits |
| dout | output | 1 | Coded output bit |
| dout_valid | output | 1 | dout carries a kept coded bit |

## Verification
Some properties hold cycle by cycle and are checked on every cycle:
- ready and valid are mutually exclusive;
- the idle condition before the first start persists;
- a start leaves the block ready and silent;
- output follows acceptance by one cycle;
- a burst never exceeds two bits;
- with puncturing off, a burst is always exactly two bits.

Other behaviour is visible only through the bench's scenarios against its queue-based model: the coded values themselves, the impulse response of both generators, the rate 2/3 and 3/4 keep patterns across long runs, the reserved rate code, and flushes that arrive mid-burst or together with an input bit.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READY,
        ST_SEND_A,
        ST_SEND_B
    } enc_state_t;

    localparam logic [1:0] RATE_HALF           = 2'b00;
    localparam logic [1:0] RATE_TWO_THIRDS     = 2'b01;
    localparam logic [1:0] RATE_THREE_QUARTERS = 2'b10;

endpackage

// File: rtl/pce_mother_code.sv
module pce_mother_code #(
    parameter int              K   = 7,
    parameter logic [K-1:0]    G_A = 7'o133,
    parameter logic [K-1:0]    G_B = 7'o171
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift,
    input  logic din,
    output logic code_a,
    output logic code_b
);
    localparam int HW = K - 1;

    // hist_q[HW-1] is the most recent past bit, hist_q[0] the oldest
    logic [HW-1:0] hist_q;
    logic [K-1:0]  window;

    assign window = {din, hist_q};
    assign code_a = ^(window & G_A);
    assign code_b = ^(window & G_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (shift) begin
            hist_q <= {din, hist_q[HW-1:1]};
        end
    end

endmodule

// File: rtl/pce_puncture_ctrl.sv
module pce_puncture_ctrl
    import pce_pkg::*;
#(
    parameter int PHASE_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       advance,
    input  logic [1:0] rate_sel,
    input  logic       punc_en,
    output logic       keep_a,
    output logic       keep_b
);
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] period;
    logic [PHASE_W-1:0] phase_inc;

    always_comb begin
        period = PHASE_W'(1);
        if (punc_en) begin
            unique case (rate_sel)
                RATE_TWO_THIRDS:     period = PHASE_W'(2);
                RATE_THREE_QUARTERS: period = PHASE_W'(3);
                default:             period = PHASE_W'(1);
            endcase
        end
    end

    always_comb begin
        keep_a = 1'b1;
        keep_b = 1'b1;
        if (punc_en) begin
            unique case (rate_sel)
                RATE_TWO_THIRDS: begin
                    if (phase_q == PHASE_W'(1)) keep_b = 1'b0;
                end
                RATE_THREE_QUARTERS: begin
                    if (phase_q == PHASE_W'(1)) keep_b = 1'b0;
                    if (phase_q == PHASE_W'(2)) keep_a = 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign phase_inc = phase_q + PHASE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clear) begin
            phase_q <= '0;
        end else if (advance) begin
            phase_q <= (phase_inc >= period) ? '0 : phase_inc;
        end
    end

endmodule

// File: rtl/conv_punct_enc.sv
module conv_punct_enc
    import pce_pkg::*;
#(
    parameter int           K       = 7,
    parameter logic [K-1:0] G_A     = 7'o133,
    parameter logic [K-1:0] G_B     = 7'o171,
    parameter int           PHASE_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       din,
    input  logic       din_valid,
    output logic       din_ready,
    input  logic [1:0] rate_sel,
    input  logic       punc_en,
    output logic       dout,
    output logic       dout_valid
);
    enc_state_t state_q, state_d;

    logic code_a, code_b;
    logic keep_a, keep_b;
    logic take;
    logic bit_a_q, bit_b_q, keep_b_q;

    assign take = (state_q == ST_READY) && din_valid && !start;

    pce_mother_code #(.K(K), .G_A(G_A), .G_B(G_B)) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .shift  (take),
        .din    (din),
        .code_a (code_a),
        .code_b (code_b)
    );

    pce_puncture_ctrl #(.PHASE_W(PHASE_W)) u_punct (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .advance  (take),
        .rate_sel (rate_sel),
        .punc_en  (punc_en),
        .keep_a   (keep_a),
        .keep_b   (keep_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_READY;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_READY: begin
                    if (din_valid) begin
                        if (keep_a)      state_d = ST_SEND_A;
                        else if (keep_b) state_d = ST_SEND_B;
                    end
                end
                ST_SEND_A: state_d = keep_b_q ? ST_SEND_B : ST_READY;
                ST_SEND_B: state_d = ST_READY;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_a_q  <= 1'b0;
            bit_b_q  <= 1'b0;
            keep_b_q <= 1'b0;
        end else if (take) begin
            bit_a_q  <= code_a;
            bit_b_q  <= code_b;
            keep_b_q <= keep_b;
        end
    end

    always_comb begin
        din_ready  = 1'b0;
        dout_valid = 1'b0;
        dout       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_READY:  din_ready = 1'b1;
            ST_SEND_A: begin
                dout_valid = 1'b1;
                dout       = bit_a_q;
            end
            ST_SEND_B: begin
                dout_valid = 1'b1;
                dout       = bit_b_q;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/pce_checker.sv
module pce_checker (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic din_valid,
    input logic din_ready,
    input logic punc_en,
    input logic dout_valid
);
    logic accepted;
    assign accepted = din_valid && din_ready && !start;

    // R8: ready never coincides with a pending output bit
    p_ready_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> !din_ready);

    // R1: the idle condition persists until start
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!din_ready && !dout_valid && !start) |=> (!din_ready && !dout_valid));

    // R7: start flushes and leaves the block ready
    p_start_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (din_ready && !dout_valid));

    // R9: an accepted bit produces output in the next cycle
    p_emit_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accepted |=> dout_valid);

    // R9: bursts are at most two bits long
    p_burst_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && $past(dout_valid)) |=> !dout_valid);

    // R9: output only rises after an acceptance
    p_rise_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_valid) |-> $past(accepted));

    // R6: without puncturing every accepted bit gives two output bits
    p_pair_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !punc_en) ##1 !start |=> dout_valid);

endmodule

bind conv_punct_enc pce_checker u_pce_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .din_valid  (din_valid),
    .din_ready  (din_ready),
    .punc_en    (punc_en),
    .dout_valid (dout_valid)
);

// File: tb/conv_punct_enc_test.sv
module conv_punct_enc_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       din = 1'b0;
    logic       din_valid = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       punc_en = 1'b0;
    logic       din_ready;
    logic       dout;
    logic       dout_valid;

    always #10 clk = ~clk;   // 50 MHz

    conv_punct_enc uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .din        (din),
        .din_valid  (din_valid),
        .din_ready  (din_ready),
        .rate_sel   (rate_sel),
        .punc_en    (punc_en),
        .dout       (dout),
        .dout_valid (dout_valid)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural reference
    bit    started = 0;
    bit    hist[6];          // hist[0] = one bit back
    int    nin = 0;
    bit    outq[$];
    bit    last_acc = 0;
    bit    seen[$];
    bit    collect = 0;

    function automatic void check_bit(string what, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endfunction

    function automatic void compare_now();
        bit e_ready, e_valid;
        e_ready = started && (outq.size() == 0);
        e_valid = (outq.size() > 0);
        check_bit("din_ready", din_ready, e_ready);
        check_bit("dout_valid", dout_valid, e_valid);
        if (e_valid) begin
            check_bit("dout", dout, outq[0]);
            if (collect) seen.push_back(dout);
        end
    endfunction

    function automatic void model_step(bit s, bit v, bit d);
        bit a, b, ka, kb;
        int pos;
        last_acc = 0;
        if (s) begin
            foreach (hist[i]) hist[i] = 0;
            nin = 0;
            outq.delete();
            started = 1;
        end else if (outq.size() > 0) begin
            void'(outq.pop_front());
        end else if (started && v) begin
            a = d ^ hist[1] ^ hist[2] ^ hist[4] ^ hist[5];
            b = d ^ hist[0] ^ hist[1] ^ hist[2] ^ hist[5];
            ka = 1; kb = 1;
            if (punc_en && rate_sel == 2'b01) begin
                pos = nin % 2;
                if (pos == 1) kb = 0;
            end else if (punc_en && rate_sel == 2'b10) begin
                pos = nin % 3;
                if (pos == 1) kb = 0;
                if (pos == 2) ka = 0;
            end
            if (ka) outq.push_back(a);
            if (kb) outq.push_back(b);
            for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = d;
            nin++;
            last_acc = 1;
        end
    endfunction

    task automatic cycle(bit s, bit v, bit d);
        @(negedge clk);
        compare_now();
        start = s; din_valid = v; din = d;
        model_step(s, v, d);
    endtask

    task automatic send(bit d);
        do cycle(1'b0, 1'b1, d); while (!last_acc);
    endtask

    task automatic drain();
        while (outq.size() > 0) cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
    endtask

    task automatic restart(logic [1:0] r, bit pe);
        @(negedge clk);
        compare_now();
        rate_sel = r; punc_en = pe;
        start = 1'b1; din_valid = 1'b0; din = 1'b0;
        model_step(1'b1, 1'b0, 1'b0);
    endtask

    task automatic run_random(int nbits, bit gaps);
        for (int i = 0; i < nbits; i++) begin
            if (gaps && ($urandom % 4 == 0)) cycle(1'b0, 1'b0, 1'b0);
            send(1'($urandom % 2));
        end
        drain();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit imp_exp[14] = '{1,1, 0,1, 1,1, 1,1, 0,0, 1,0, 1,1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: no start yet, din_valid ignored
        cur_req = "R1";
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b1, 1'($urandom % 2));
        cycle(1'b0, 1'b0, 1'b0);

        // R2 / R3: impulse response at rate 1/2 (00) with punc_en high
        cur_req = "R2";
        restart(2'b00, 1'b1);
        collect = 1;
        send(1'b1);
        for (int i = 0; i < 6; i++) send(1'b0);
        drain();
        collect = 0;
        n_cmp++;
        if (seen.size() != 14) begin
            n_bad++;
            $display("FAIL R2 impulse length: actual %0d expected 14", seen.size());
        end else begin
            for (int i = 0; i < 14; i++) check_bit("impulse", seen[i], imp_exp[i]);
        end

        cur_req = "R2/R8/R9";
        run_random(20, 1'b1);

        cur_req = "R4/R8/R9";
        restart(2'b01, 1'b1);
        run_random(24, 1'b1);

        cur_req = "R5/R8/R9";
        restart(2'b10, 1'b1);
        run_random(30, 1'b1);

        cur_req = "R6";
        restart(2'b10, 1'b0);
        run_random(12, 1'b0);
        restart(2'b01, 1'b0);
        run_random(12, 1'b1);

        cur_req = "R3";
        restart(2'b11, 1'b1);
        run_random(12, 1'b0);

        // R7: start in the middle of a burst
        cur_req = "R7";
        restart(2'b10, 1'b1);
        send(1'b1);
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        run_random(6, 1'b0);
        // R7: start together with a valid input bit
        send(1'b1);
        drain();
        cycle(1'b1, 1'b1, 1'b1);
        cycle(1'b0, 1'b0, 1'b0);
        run_random(9, 1'b1);

        cycle(1'b0, 1'b0, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule